// File: doc/BRIEF.md
# Per-Port Sticky Interrupt Status

This block keeps the interrupt and status state of one host-facing port. Event inputs from the port logic set sticky cause bits. Each bit stays set until the local CPU clears it by writing a one to its position. A per-cause mask chooses which pending causes may raise the port interrupt. A separate port-level enable gates the single interrupt line. The CPU can also write a group of application-defined user bits. The block joins these with hardware-generated status inputs to form the status byte that is returned to the host.

The CPU side is a plain, single-cycle register port: a write strobe, a 2-bit register select, write data and combinational read data. The status byte and the interrupt are plain level outputs. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Register select values: 0 = causes (read, write-1-to-clear), 1 = mask, 2 = user bits, 3 = port enable.

Top module: `psis_top`

## Requirements
- R1: After reset, causes, mask, user bits and enable read back as zero and `irq_o` is low.
- R2: A high bit of `evt_i` sets the matching cause bit at the next clock edge, whatever the mask and enable hold. The bit then stays set.
- R3: A write to select 0 clears each cause bit whose position in the write data (bits 3:0) is 1. Positions written with 0 keep their value.
- R4: When an event and a write-1-clear hit the same cause bit in the same cycle, the bit ends up set.
- R5: `irq_o` is high exactly when some cause bit is set whose mask bit is 1 and the port enable is 1.
- R6: With the mask all zero, `irq_o` stays low whatever causes are pending.
- R7: `host_status_o` is the user bits in bits 7:4 and `auto_stat_i` in bits 3:0.
- R8: Writing 1 to the enable (select 3, data bit 0) while unmasked causes are pending raises `irq_o` in the cycle right after the write edge.
- R9: Mask writes take data bits 3:0 and user writes take data bits 7:4. Enable writes take bit 0 only. Each reads back in the same bit positions, with all other read bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 4 | Event pulses, one per cause |
| auto_stat_i | input | 4 | Hardware-generated status bits |
| reg_wr_i | input | 1 | CPU register write strobe |
| reg_addr_i | input | 2 | CPU register select |
| reg_wdata_i | input | 8 | CPU write data |
| reg_rdata_o | output | 8 | CPU read data, combinational on select |
| host_status_o | output | 8 | Status byte returned to the host |
| irq_o | output | 1 | Port interrupt |

## Verification
Cause, mask, user and enable state changes at the clock edge that samples the event or write. Because `irq_o`, `reg_rdata_o` and `host_status_o` are combinational from that state, their new values are due one edge after the stimulus. `host_status_o` also follows `auto_stat_i` with no delay. The bench drives each stimulus on the falling edge and lets one rising edge pass. It then removes the stimulus, points the read select at the register under test and compares a little after that edge. Each check therefore sees exactly the state written by the one edge under test.

// File: rtl/psis_pkg.sv
package psis_pkg;
  typedef enum logic [1:0] {
    SEL_CAUSE = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_USER  = 2'd2,
    SEL_EN    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/psis_cause_bank.sv
module psis_cause_bank #(
  parameter int NUM_CAUSE = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CAUSE-1:0] evt_i,
  input  logic [NUM_CAUSE-1:0] clr_i,
  output logic [NUM_CAUSE-1:0] cause_o
);
  for (genvar g = 0; g < NUM_CAUSE; g++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!rst_n)          bit_q <= 1'b0;
      else if (evt_i[g])   bit_q <= 1'b1;   // set has priority over clear
      else if (clr_i[g])   bit_q <= 1'b0;
    end
    assign cause_o[g] = bit_q;
  end
endmodule

// File: rtl/psis_ctrl_regs.sv
module psis_ctrl_regs
  import psis_pkg::*;
#(
  parameter int NUM_CAUSE = 4,
  parameter int USER_W    = 4,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_i,
  input  logic [1:0]           addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [NUM_CAUSE-1:0] clr_o,
  output logic [NUM_CAUSE-1:0] mask_o,
  output logic [USER_W-1:0]    user_o,
  output logic                 en_o
);
  reg_sel_e sel;
  assign sel   = reg_sel_e'(addr_i);
  assign clr_o = (wr_i && sel == SEL_CAUSE) ? wdata_i[NUM_CAUSE-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_o <= '0;
      user_o <= '0;
      en_o   <= 1'b0;
    end else if (wr_i) begin
      case (sel)
        SEL_MASK: mask_o <= wdata_i[NUM_CAUSE-1:0];
        SEL_USER: user_o <= wdata_i[DATA_W-1 -: USER_W];
        SEL_EN:   en_o   <= wdata_i[0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/psis_readout.sv
module psis_readout
  import psis_pkg::*;
#(
  parameter int NUM_CAUSE = 4,
  parameter int USER_W    = 4,
  parameter int AUTO_W    = 4,
  parameter int DATA_W    = 8
) (
  input  logic [1:0]             addr_i,
  input  logic [NUM_CAUSE-1:0]   cause_i,
  input  logic [NUM_CAUSE-1:0]   mask_i,
  input  logic [USER_W-1:0]      user_i,
  input  logic                   en_i,
  input  logic [AUTO_W-1:0]      auto_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic [USER_W+AUTO_W-1:0] status_o
);
  assign status_o = {user_i, auto_i};

  always_comb begin
    rdata_o = '0;
    case (reg_sel_e'(addr_i))
      SEL_CAUSE: rdata_o[NUM_CAUSE-1:0]   = cause_i;
      SEL_MASK:  rdata_o[NUM_CAUSE-1:0]   = mask_i;
      SEL_USER:  rdata_o[DATA_W-1 -: USER_W] = user_i;
      SEL_EN:    rdata_o[0]               = en_i;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/psis_irq_gen.sv
module psis_irq_gen #(
  parameter int NUM_CAUSE = 4
) (
  input  logic [NUM_CAUSE-1:0] cause_i,
  input  logic [NUM_CAUSE-1:0] mask_i,
  input  logic                 en_i,
  output logic                 irq_o
);
  logic [NUM_CAUSE-1:0] armed;
  assign armed = cause_i & mask_i;
  assign irq_o = en_i & (|armed);
endmodule

// File: rtl/psis_top.sv
module psis_top #(
  parameter int NUM_CAUSE = 4,
  parameter int USER_W    = 4,
  parameter int AUTO_W    = 4,
  parameter int DATA_W    = 8,
  localparam int STAT_W   = USER_W + AUTO_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CAUSE-1:0] evt_i,
  input  logic [AUTO_W-1:0]    auto_stat_i,
  input  logic                 reg_wr_i,
  input  logic [1:0]           reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  output logic [STAT_W-1:0]    host_status_o,
  output logic                 irq_o
);
  logic [NUM_CAUSE-1:0] cause_q, mask_q, clr_vec;
  logic [USER_W-1:0]    user_q;
  logic                 en_q;

  psis_ctrl_regs #(.NUM_CAUSE(NUM_CAUSE), .USER_W(USER_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .clr_o(clr_vec), .mask_o(mask_q),
    .user_o(user_q), .en_o(en_q)
  );

  psis_cause_bank #(.NUM_CAUSE(NUM_CAUSE)) u_bank (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_i(clr_vec), .cause_o(cause_q)
  );

  psis_irq_gen #(.NUM_CAUSE(NUM_CAUSE)) u_irq (
    .cause_i(cause_q), .mask_i(mask_q), .en_i(en_q), .irq_o(irq_o)
  );

  psis_readout #(.NUM_CAUSE(NUM_CAUSE), .USER_W(USER_W), .AUTO_W(AUTO_W),
                 .DATA_W(DATA_W)) u_rd (
    .addr_i(reg_addr_i), .cause_i(cause_q), .mask_i(mask_q), .user_i(user_q),
    .en_i(en_q), .auto_i(auto_stat_i), .rdata_o(reg_rdata_o),
    .status_o(host_status_o)
  );
endmodule

// File: rtl/psis_sva.sv
module psis_sva #(
  parameter int NUM_CAUSE = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CAUSE-1:0] evt,
  input logic [NUM_CAUSE-1:0] clr,
  input logic [NUM_CAUSE-1:0] cause,
  input logic [NUM_CAUSE-1:0] mask,
  input logic                 en,
  input logic                 irq
);
  // R2: pending causes never drop without a clear request
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (clr == '0) |=> ((cause & $past(cause)) == $past(cause)));

  // R4: an event always leaves its bit set, even under a clear
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((cause & $past(evt)) == $past(evt)));

  // R3: cleared positions without a concurrent event end up zero
  a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |=> ((cause & $past(clr & ~evt)) == '0));

  // R5: no interrupt while the port is disabled
  a_r5_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irq);

  // R6: no interrupt with the mask all zero
  a_r6_nomask: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);

  // R8: enabling with armed causes gives an interrupt at once
  a_r8_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(en) && ((cause & mask) != '0)) |-> irq);
endmodule

bind psis_top psis_sva #(.NUM_CAUSE(NUM_CAUSE)) u_sva (
  .clk(clk), .rst_n(rst_n), .evt(evt_i), .clr(clr_vec), .cause(cause_q),
  .mask(mask_q), .en(en_q), .irq(irq_o)
);

// File: tb/tb_psis_top.sv
module tb_psis_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] evt_i = '0;
  logic [3:0] auto_stat_i = '0;
  logic       reg_wr_i = 1'b0;
  logic [1:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o, host_status_o;
  logic       irq_o;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  psis_top dut (.*);

  // vector: evt[19:16] wr[15] sel[14:13] wdata[12:5] exp_cause[4:1] exp_irq[0]
  localparam int NV = 12;
  localparam logic [19:0] VEC [NV] = '{
    {4'b0001, 1'b0, 2'd0, 8'h00, 4'b0001, 1'b0}, // R2 R6 set while masked
    {4'b0000, 1'b1, 2'd1, 8'h03, 4'b0001, 1'b0}, // R5 mask, enable off
    {4'b0000, 1'b1, 2'd3, 8'h01, 4'b0001, 1'b1}, // R8 enable with pending
    {4'b0100, 1'b0, 2'd0, 8'h00, 4'b0101, 1'b1}, // R2 second cause
    {4'b0000, 1'b1, 2'd0, 8'h01, 4'b0100, 1'b0}, // R3 clear one bit
    {4'b0000, 1'b1, 2'd0, 8'h00, 4'b0100, 1'b0}, // R3 zero write no effect
    {4'b0100, 1'b1, 2'd0, 8'h04, 4'b0100, 1'b0}, // R4 set wins
    {4'b0000, 1'b1, 2'd1, 8'h04, 4'b0100, 1'b1}, // R5 unmask pending
    {4'b0000, 1'b1, 2'd3, 8'h00, 4'b0100, 1'b0}, // R5 disable
    {4'b0000, 1'b1, 2'd0, 8'h0F, 4'b0000, 1'b0}, // R3 clear all
    {4'b1000, 1'b0, 2'd0, 8'h00, 4'b1000, 1'b0}, // R2 set while disabled
    {4'b0000, 1'b1, 2'd1, 8'h00, 4'b1000, 1'b0}  // R6 mask zero
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, then read back after the rising edge
  task automatic step(logic [3:0] e, logic w, logic [1:0] s, logic [7:0] d);
    @(negedge clk);
    evt_i = e; reg_wr_i = w; reg_addr_i = s; reg_wdata_i = d;
    @(posedge clk);
    #1;
    evt_i = '0; reg_wr_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] s, string req, logic [7:0] exp);
    reg_addr_i = s;
    #1;
    check(req, {24'd0, reg_rdata_o}, {24'd0, exp});
  endtask

  initial begin
    auto_stat_i = 4'h5;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    for (int s = 0; s < 4; s++) rd(s[1:0], "R1", 8'h00);
    check("R1 irq", {31'd0, irq_o}, 32'd0);
    check("R1 status", {24'd0, host_status_o}, 32'h05);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][19:16], VEC[i][15], VEC[i][14:13], VEC[i][12:5]);
      rd(2'd0, $sformatf("vec%0d cause R2/R3/R4", i), {4'h0, VEC[i][4:1]});
      check($sformatf("vec%0d irq R5/R6/R8", i), {31'd0, irq_o}, {31'd0, VEC[i][0]});
    end
    // R6: enable on, mask zero, cause pending -> still low
    step(4'b0000, 1'b1, 2'd3, 8'hFF);
    check("R6 irq", {31'd0, irq_o}, 32'd0);
    // R9 field positions and readback
    rd(2'd3, "R9 enable bit0 only", 8'h01);
    step(4'b0000, 1'b1, 2'd1, 8'hFA);
    rd(2'd1, "R9 mask low nibble", 8'h0A);
    check("R5 irq masked cause", {31'd0, irq_o}, 32'd1);
    step(4'b0000, 1'b1, 2'd2, 8'hA3);
    rd(2'd2, "R9 user high nibble", 8'hA0);
    // R7 status byte composition
    check("R7 status", {24'd0, host_status_o}, 32'hA5);
    auto_stat_i = 4'hC; #1;
    check("R7 status auto follows", {24'd0, host_status_o}, 32'hAC);
    // R8: disable, then re-enable with pending armed cause
    step(4'b0000, 1'b1, 2'd3, 8'h00);
    check("R8 irq off", {31'd0, irq_o}, 32'd0);
    step(4'b0000, 1'b1, 2'd3, 8'h01);
    check("R8 irq next cycle", {31'd0, irq_o}, 32'd1);
    // R1 reset in mid-run clears all state
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    for (int s = 0; s < 4; s++) rd(s[1:0], "R1 rerun", 8'h00);
    check("R1 irq rerun", {31'd0, irq_o}, 32'd0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule